// File: doc/BRIEF.md
# Linear Systolic 1-D Convolution Pipeline

The block computes a one-dimensional convolution Z(c) = sum over q = 0..Q-1 of x(c+q)·w(q) on a chain of S lanes. The work is placed by a space-time projection: iteration (c, q) runs on lane s = c + q during step t = q. Every lane holds one sample. During step q all lanes multiply their sample by the single broadcast weight w(q) and add the product to the partial sum they just received from their lower neighbour. Partial sums travel one lane up the chain per step, so the sum for output c collects its Q terms while moving from lane c to lane c+Q-1.

Software-side logic loads the Q weights once through a small write port. A start pulse then captures a whole sample vector. After Q steps the S-Q+1 finished results are read out of the top lanes one per cycle, in ascending c, with a valid strobe. A block ends when its last result leaves. The weights stay in place for later blocks until they are rewritten.

Top module: `conv1d_systolic`

## Requirements
- R1: While reset is active, and after it until the first accepted start, `zValid` is low.
- R2: Each result equals the sum of x(c+q)·w(q) for q = 0..Q-1. Samples and weights are two's-complement signed values, and the sum is a signed SW-bit value.
- R3: Sample x(s) is taken from `xVec[s*DW +: DW]` on the clock edge that accepts `start`. A change of `xVec` after that edge has no effect on the results of the block.
- R4: A cycle with `wWe` high stores `wData` as weight w(`wAddr`). A write with `wAddr` >= Q is ignored. Weights persist across blocks.
- R5: For a start accepted at edge E0, result c (c = 0..S-Q) is presented with `zValid` high after edge E0+Q+1+c. There is exactly one result per cycle, in ascending c, and `zValid` is low again after edge E0+S+2.
- R6: A `start` that arrives while a block is in progress (from the accepting edge through the edge that emits the last result) is ignored. It produces no extra results and does not disturb the running block.
- R7: A new start may be accepted on the edge right after the one that emits the previous block's last result, which gives back-to-back blocks with no idle cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous active-low reset |
| wWe | input | 1 | Weight write enable |
| wAddr | input | TAP_W | Weight index q for the write |
| wData | input | DW | Signed weight value |
| start | input | 1 | Begins a block when the block is idle |
| xVec | input | LANES*DW | Sample vector, lane s in bits [s*DW +: DW] |
| zOut | output | SW | Signed convolution result |
| zValid | output | 1 | High while `zOut` carries a result |

## Verification
Every result has a fixed slot. Result c of a block whose start is taken at edge E0 is due Q+1+c edges later: one edge for capture, Q MAC steps, then one output register per result in order. When the bench drives a start, its driver task records the cycle number and pushes each expected value together with its due cycle into a scoreboard queue. A monitor samples on the falling edge and compares both the value and the cycle. A result that arrives when the queue is empty, or that arrives late or early, is counted as a failure. Ignored starts are detected this way as unexpected extra results.

// File: rtl/conv1d_pkg.sv
package conv1d_pkg;

  // strobes driven from control to datapath each cycle
  typedef struct packed {
    logic loadX;      // capture sample vector
    logic macEn;      // perform one space-time step
    logic firstStep;  // step q = 0: start partial sums from zero
    logic emit;       // present one finished result
  } convCtl_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RUN   = 2'd1,
    ST_DRAIN = 2'd2
  } convState_t;

endpackage

// File: rtl/conv1d_ctrl.sv
module conv1d_ctrl
  import conv1d_pkg::*;
#(
  parameter int LANES  = 8,
  parameter int TAPS   = 3,
  parameter int TAP_W  = 2,
  parameter int LANE_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  output convCtl_t          ctl,
  output logic [TAP_W-1:0]  tapSel,
  output logic [LANE_W-1:0] outSel
);

  localparam int NUM_OUT = LANES - TAPS + 1;
  localparam logic [TAP_W-1:0]  LAST_STEP = TAP_W'(TAPS - 1);
  localparam logic [LANE_W-1:0] LAST_OUT  = LANE_W'(NUM_OUT - 1);
  localparam logic [LANE_W-1:0] OUT_BASE  = LANE_W'(TAPS - 1);

  convState_t        state;
  logic [TAP_W-1:0]  stepCnt;
  logic [LANE_W-1:0] drainCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      stepCnt  <= '0;
      drainCnt <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (start) begin
            state   <= ST_RUN;
            stepCnt <= '0;
          end
        end
        ST_RUN: begin
          if (stepCnt == LAST_STEP) begin
            state    <= ST_DRAIN;
            drainCnt <= '0;
          end else begin
            stepCnt <= stepCnt + 1'b1;
          end
        end
        ST_DRAIN: begin
          if (drainCnt == LAST_OUT) begin
            state <= ST_IDLE;
          end else begin
            drainCnt <= drainCnt + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    ctl.loadX     = (state == ST_IDLE) && start;
    ctl.macEn     = (state == ST_RUN);
    ctl.firstStep = (state == ST_RUN) && (stepCnt == '0);
    ctl.emit      = (state == ST_DRAIN);
    tapSel        = stepCnt;
    // after the last step, result c sits in lane c + TAPS - 1
    outSel        = OUT_BASE + drainCnt;
  end

endmodule

// File: rtl/conv1d_datapath.sv
module conv1d_datapath
  import conv1d_pkg::*;
#(
  parameter int LANES  = 8,
  parameter int TAPS   = 3,
  parameter int DW     = 8,
  parameter int SW     = 24,
  parameter int TAP_W  = 2,
  parameter int LANE_W = 3
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  wWe,
  input  logic [TAP_W-1:0]      wAddr,
  input  logic [DW-1:0]         wData,
  input  logic [LANES*DW-1:0]   xVec,
  input  convCtl_t              ctl,
  input  logic [TAP_W-1:0]      tapSel,
  input  logic [LANE_W-1:0]     outSel,
  output logic signed [SW-1:0]  zOut,
  output logic                  zValid
);

  localparam int PW = 2 * DW;

  logic signed [DW-1:0] wReg   [TAPS];
  logic signed [DW-1:0] xReg   [LANES];
  logic signed [SW-1:0] accReg [LANES];
  logic signed [DW-1:0] curW;

  // weight register file, one entry per tap
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < TAPS; i++) wReg[i] <= '0;
    end else if (wWe && (int'(wAddr) < TAPS)) begin
      wReg[wAddr] <= wData;
    end
  end

  // broadcast weight of the current step
  always_comb begin
    curW = '0;
    for (int i = 0; i < TAPS; i++) begin
      if (tapSel == TAP_W'(i)) curW = wReg[i];
    end
  end

  // sample capture: lane s holds x(s)
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < LANES; i++) xReg[i] <= '0;
    end else if (ctl.loadX) begin
      for (int i = 0; i < LANES; i++) xReg[i] <= xVec[i*DW +: DW];
    end
  end

  // lanes: multiply-add, then neighbour shift toward higher lane index
  for (genvar g = 0; g < LANES; g++) begin : gLane
    logic signed [PW-1:0] prod;
    logic signed [SW-1:0] accIn;

    assign prod = xReg[g] * curW;

    if (g == 0) begin : gHead
      assign accIn = '0;
    end else begin : gBody
      assign accIn = ctl.firstStep ? '0 : accReg[g-1];
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        accReg[g] <= '0;
      end else if (ctl.macEn) begin
        accReg[g] <= accIn + SW'(prod);
      end
    end
  end

  // output stage
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      zOut   <= '0;
      zValid <= 1'b0;
    end else begin
      zValid <= ctl.emit;
      if (ctl.emit) zOut <= accReg[outSel];
    end
  end

endmodule

// File: rtl/conv1d_systolic.sv
module conv1d_systolic
  import conv1d_pkg::*;
#(
  parameter int LANES  = 8,
  parameter int TAPS   = 3,
  parameter int DW     = 8,
  parameter int SW     = 24,
  parameter int TAP_W  = (TAPS > 1) ? $clog2(TAPS) : 1,
  parameter int LANE_W = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 wWe,
  input  logic [TAP_W-1:0]     wAddr,
  input  logic [DW-1:0]        wData,
  input  logic                 start,
  input  logic [LANES*DW-1:0]  xVec,
  output logic [SW-1:0]        zOut,
  output logic                 zValid
);

  convCtl_t          ctl;
  logic [TAP_W-1:0]  tapSel;
  logic [LANE_W-1:0] outSel;
  logic signed [SW-1:0] zData;

  conv1d_ctrl #(
    .LANES (LANES),
    .TAPS  (TAPS),
    .TAP_W (TAP_W),
    .LANE_W(LANE_W)
  ) u_ctrl (
    .clk   (clk),
    .rstN  (rstN),
    .start (start),
    .ctl   (ctl),
    .tapSel(tapSel),
    .outSel(outSel)
  );

  conv1d_datapath #(
    .LANES (LANES),
    .TAPS  (TAPS),
    .DW    (DW),
    .SW    (SW),
    .TAP_W (TAP_W),
    .LANE_W(LANE_W)
  ) u_dp (
    .clk   (clk),
    .rstN  (rstN),
    .wWe   (wWe),
    .wAddr (wAddr),
    .wData (wData),
    .xVec  (xVec),
    .ctl   (ctl),
    .tapSel(tapSel),
    .outSel(outSel),
    .zOut  (zData),
    .zValid(zValid)
  );

  assign zOut = zData;

endmodule

// File: rtl/conv1d_systolic_chk.sv
module conv1d_systolic_chk #(
  parameter int LANES = 8,
  parameter int TAPS  = 3,
  parameter int SW    = 24
) (
  input logic          clk,
  input logic          rstN,
  input logic          start,
  input logic          zValid,
  input logic [SW-1:0] zOut
);

  localparam int FINAL = LANES + 2;   // count after the last result edge
  localparam int FIRST = TAPS + 2;    // count after the first result edge
  localparam int CW    = $clog2(LANES + 3);

  // block-position counter built only from port activity
  logic [CW-1:0] blkCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      blkCnt <= '0;
    end else if (((blkCnt == '0) || (blkCnt == CW'(FINAL))) && start) begin
      blkCnt <= CW'(1);
    end else if (blkCnt == CW'(FINAL)) begin
      blkCnt <= '0;
    end else if (blkCnt != '0) begin
      blkCnt <= blkCnt + 1'b1;
    end
  end

  // R1: reset keeps the output strobe quiet
  a_r1_reset_quiet: assert property (@(posedge clk) !rstN |=> !zValid);

  // R5, R6, R7: strobe high exactly in the result window of an accepted start
  a_r5_valid_window: assert property (@(posedge clk) disable iff (!rstN)
    zValid == (int'(blkCnt) >= FIRST));

  // R5: strobe drops only once the block has finished
  a_r5_clean_end: assert property (@(posedge clk) disable iff (!rstN)
    $fell(zValid) |-> ((blkCnt == '0) || (blkCnt == CW'(1))));

  // R2: a presented result is fully defined
  a_r2_known_result: assert property (@(posedge clk) disable iff (!rstN)
    zValid |-> !$isunknown(zOut));

endmodule

bind conv1d_systolic conv1d_systolic_chk #(
  .LANES(LANES),
  .TAPS (TAPS),
  .SW   (SW)
) u_chk (
  .clk   (clk),
  .rstN  (rstN),
  .start (start),
  .zValid(zValid),
  .zOut  (zOut)
);

// File: tb/conv1d_systolic_bench.sv
module conv1d_systolic_bench;

  localparam int LANES   = 8;
  localparam int TAPS    = 3;
  localparam int DW      = 8;
  localparam int SW      = 24;
  localparam int TAP_W   = 2;
  localparam int NUM_OUT = LANES - TAPS + 1;

  logic                clk = 1'b0;
  logic                rstN = 1'b0;
  logic                wWe = 1'b0;
  logic [TAP_W-1:0]    wAddr = '0;
  logic [DW-1:0]       wData = '0;
  logic                start = 1'b0;
  logic [LANES*DW-1:0] xVec = '0;
  logic [SW-1:0]       zOut;
  logic                zValid;

  conv1d_systolic #(
    .LANES(LANES), .TAPS(TAPS), .DW(DW), .SW(SW)
  ) u_conv1d_systolic (
    .clk(clk), .rstN(rstN), .wWe(wWe), .wAddr(wAddr), .wData(wData),
    .start(start), .xVec(xVec), .zOut(zOut), .zValid(zValid)
  );

  always #2 clk = ~clk;   // 250 MHz

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    logic signed [SW-1:0] v;
    int due;
    int c;
  } exp_t;
  exp_t scb[$];

  logic signed [DW-1:0] wSh  [TAPS];
  logic signed [DW-1:0] xArr [LANES];

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic writeW(input int addr, input logic [DW-1:0] data);
    @(negedge clk);
    wWe   = 1'b1;
    wAddr = TAP_W'(addr);
    wData = data;
    @(negedge clk);
    wWe = 1'b0;
    if (addr < TAPS) wSh[addr] = data;   // R4: out-of-range writes ignored
  endtask

  // driver: pulse start at the current falling edge, push expected results
  task automatic runBlock(input bit scramble, input bit poke);
    int left;
    for (int i = 0; i < LANES; i++) xVec[i*DW +: DW] = xArr[i];
    for (int c = 0; c < NUM_OUT; c++) begin
      longint sum = 0;
      exp_t it;
      for (int q = 0; q < TAPS; q++) sum += longint'(xArr[c+q]) * longint'(wSh[q]);
      it.v   = SW'(sum);
      it.due = cyc + TAPS + 2 + c;   // R5: slot of result c
      it.c   = c;
      scb.push_back(it);
    end
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    left  = LANES + 1;
    if (scramble) xVec = {LANES{8'h5a}} ^ LANES*DW'($urandom);   // R3
    if (poke) begin
      // R6: starts during run step and during drain must be ignored
      @(negedge clk);
      start = 1'b1;
      xVec  = LANES*DW'($urandom);
      @(negedge clk);
      start = 1'b0;
      repeat (2) @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      left  = left - 4;
    end
    repeat (left) @(negedge clk);
  endtask

  task automatic randX();
    for (int i = 0; i < LANES; i++) xArr[i] = DW'($urandom);
  endtask

  // monitor: compare value and arrival cycle
  always @(negedge clk) begin
    if (rstN && zValid) begin
      if (scb.size() == 0) begin
        check(1'b0, "R6", "unexpected result", longint'($signed(zOut)), 0);
      end else begin
        exp_t it;
        it = scb.pop_front();
        check($signed(zOut) == it.v, "R2", $sformatf("value c=%0d", it.c),
              longint'($signed(zOut)), longint'(it.v));
        check(cyc == it.due, "R5", $sformatf("arrival cycle c=%0d", it.c),
              cyc, it.due);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int q = 0; q < TAPS; q++) wSh[q] = '0;
    repeat (3) @(negedge clk);
    check(zValid == 1'b0, "R1", "strobe in reset", zValid, 0);
    rstN = 1'b1;
    repeat (3) begin
      @(negedge clk);
      check(zValid == 1'b0, "R1", "strobe before start", zValid, 0);
    end

    // R4 basic load, ramp samples, R2
    writeW(0, 8'd1);
    writeW(1, 8'd2);
    writeW(2, 8'd3);
    for (int i = 0; i < LANES; i++) xArr[i] = DW'(i);
    @(negedge clk);
    runBlock(1'b0, 1'b0);

    // R4: out-of-range address ignored, weights persist
    writeW(3, 8'h7f);
    randX();
    @(negedge clk);
    runBlock(1'b0, 1'b0);

    // R2 extremes: most negative times most negative
    for (int q = 0; q < TAPS; q++) writeW(q, 8'h80);
    for (int i = 0; i < LANES; i++) xArr[i] = 8'sh80;
    @(negedge clk);
    runBlock(1'b0, 1'b0);

    // R2 mixed signs
    for (int i = 0; i < LANES; i++) xArr[i] = (i % 2 == 0) ? 8'sh7f : 8'sh80;
    @(negedge clk);
    runBlock(1'b0, 1'b0);

    // R3: sample vector changed right after capture
    writeW(0, 8'hfd);
    writeW(1, 8'h11);
    writeW(2, 8'h40);
    randX();
    @(negedge clk);
    runBlock(1'b1, 1'b0);

    // R6: starts while busy
    randX();
    @(negedge clk);
    runBlock(1'b0, 1'b1);
    repeat (4) begin
      @(negedge clk);
      check(zValid == 1'b0, "R6", "no extra results after block", zValid, 0);
    end

    // R7: back-to-back random blocks, weights reloaded now and then
    for (int b = 0; b < 12; b++) begin
      if (b % 3 == 0) begin
        for (int q = 0; q < TAPS; q++) begin
          wWe   = 1'b1;
          wAddr = TAP_W'(q);
          wData = DW'($urandom);
          wSh[q] = wData;
          @(negedge clk);
        end
        wWe = 1'b0;
      end
      randX();
      runBlock(1'b0, 1'b0);
    end

    repeat (12) @(negedge clk);
    check(scb.size() == 0, "R5", "results outstanding", scb.size(), 0);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule